// File: doc/BRIEF.md
# Unaligned Parallel Window Word Router

This block supplies a row of parallel evaluation kernels with the values found at consecutive horizontal positions of an integral image, all from a single memory access. Kernel lane i needs the word one pixel to the right of the word for lane i-1. The first lane may start at any position, so the sixteen words it needs usually straddle two naturally aligned 16-word chunks.

The router handles this with two memories that hold identical contents and each return one full chunk per read. The router splits the window address into a chunk index and a start offset. It then presents the chunk index to one memory and the following chunk index to the other. One cycle later the two chunks arrive. A funnel, steered by the registered offset, picks sixteen consecutive words out of the 32 words it now has. The routed row is registered, so a routed result appears two cycles after its request.

The word width is a parameter. It is 21 bits for the plain integral and 29 bits for the squared integral, and the same module serves both.

Top module: `win_word_router`

## Requirements
- R1: While reset is asserted and after reset until the first routed result, `lanes_valid_o` is 0 and `lanes_o` is all zero.
- R2: `rd_lo_addr_o` equals bits [12:4] of `win_addr_i` in the same cycle, without a register in between.
- R3: `rd_hi_addr_o` equals `rd_lo_addr_o` plus one, modulo 512, so chunk 511 is followed by chunk 0.
- R4: Both memories return their chunk on `lo_data_i` and `hi_data_i` one cycle after the address. `lanes_valid_o` is high exactly two clock edges after the edge that samples `win_valid_i` high.
- R5: Let the 32-word set have words 0 to 15 taken from `lo_data_i` and words 16 to 31 taken from `hi_data_i`, with word k at bits [k*W +: W] of its bus. For offset s = `win_addr_i`[3:0], lane i (bits [i*W +: W] of `lanes_o`) receives word s+i. For example, address 3 routes words 3 to 18 to lanes 0 to 15.
- R6: At offset 0 the lanes carry exactly `lo_data_i`, and the contents of `hi_data_i` have no effect on the result.
- R7: At offset 15, lane 0 carries word 15 of `lo_data_i` and lanes 1 to 15 carry words 0 to 14 of `hi_data_i`.
- R8: In a cycle that delivers no routed result, `lanes_o` keeps its previous value.
- R9: Requests on consecutive cycles are each routed with their own offset, producing one result per cycle in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| win_valid_i | input | 1 | Window request strobe |
| win_addr_i | input | 13 | Window start: chunk index [12:4], start offset [3:0] |
| rd_lo_addr_o | output | 9 | Read address to the first memory copy |
| rd_hi_addr_o | output | 9 | Read address to the second memory copy (next chunk) |
| lo_data_i | input | 16*WORD_W | Chunk returned by the first copy, one cycle after its address |
| hi_data_i | input | 16*WORD_W | Chunk returned by the second copy, one cycle after its address |
| lanes_valid_o | output | 1 | Routed row valid |
| lanes_o | output | 16*WORD_W | Routed words, lane i at bits [i*WORD_W +: WORD_W] |

## Verification
Several properties are checked on every cycle. These are the adjacency of the two read addresses, the request-to-result valid pipeline, holding the output across bubbles, and the two extreme offsets (0 passing the first chunk through unchanged, and 15 splitting one word and fifteen words across the two chunks).

Other behaviour can only be shown by the bench's scenarios, because they need a model of the memory contents. These are the full routing for every intermediate offset, the wrap from the last chunk to chunk 0, corrupted second-copy data being ignored at offset 0, and correct ordering under back-to-back requests with mixed offsets.

// File: rtl/wwr_pkg.sv
package wwr_pkg;
  localparam int unsigned WWR_LANES_DEF  = 16;
  localparam int unsigned WWR_WORD_W_DEF = 21;
  localparam int unsigned WWR_ADDR_W_DEF = 13;

  typedef enum logic [0:0] {
    STG_IDLE = 1'b0,
    STG_BUSY = 1'b1
  } stg_state_e;
endpackage

// File: rtl/wwr_addr_split.sv
module wwr_addr_split #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned OFS_W  = 4,
  localparam int unsigned CHUNK_W = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0]  win_addr,
  output logic [CHUNK_W-1:0] chunk_lo,
  output logic [CHUNK_W-1:0] chunk_hi,
  output logic [OFS_W-1:0]   ofs
);
  always_comb begin
    chunk_lo = win_addr[ADDR_W-1:OFS_W];
    chunk_hi = win_addr[ADDR_W-1:OFS_W] + CHUNK_W'(1);
    ofs      = win_addr[OFS_W-1:0];
  end
endmodule

// File: rtl/wwr_sel_pipe.sv
module wwr_sel_pipe
  import wwr_pkg::*;
#(
  parameter int unsigned OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [OFS_W-1:0] in_ofs,
  output logic             out_vld,
  output logic [OFS_W-1:0] out_ofs
);
  stg_state_e       st_q, st_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic             ofs_en;

  always_comb begin
    st_d   = in_vld ? STG_BUSY : STG_IDLE;
    ofs_en = in_vld;
    ofs_d  = in_ofs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= STG_IDLE;
      ofs_q <= '0;
    end else begin
      st_q <= st_d;
      if (ofs_en) ofs_q <= ofs_d;
    end
  end

  assign out_vld = (st_q == STG_BUSY);
  assign out_ofs = ofs_q;
endmodule

// File: rtl/wwr_funnel.sv
module wwr_funnel #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned WORD_W = 21,
  parameter int unsigned OFS_W  = 4,
  localparam int unsigned ROW_W = LANES * WORD_W,
  localparam int unsigned IDX_W = OFS_W + 1
) (
  input  logic [ROW_W-1:0] lo_row,
  input  logic [ROW_W-1:0] hi_row,
  input  logic [OFS_W-1:0] sel,
  output logic [ROW_W-1:0] out_row
);
  logic [WORD_W-1:0] words [2*LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_unpack
    assign words[k]         = lo_row[k*WORD_W +: WORD_W];
    assign words[k + LANES] = hi_row[k*WORD_W +: WORD_W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [IDX_W-1:0] idx;
    always_comb begin
      idx = IDX_W'(sel) + IDX_W'(i);
      out_row[i*WORD_W +: WORD_W] = words[idx];
    end
  end
endmodule

// File: rtl/wwr_out_stage.sv
module wwr_out_stage #(
  parameter int unsigned DATA_W = 336
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);
  logic              vld_d;
  logic [DATA_W-1:0] data_d;
  logic              data_en;

  always_comb begin
    vld_d   = in_vld;
    data_en = in_vld;
    data_d  = in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= vld_d;
      if (data_en) out_data <= data_d;
    end
  end
endmodule

// File: rtl/win_word_router.sv
module win_word_router
  import wwr_pkg::*;
#(
  parameter int unsigned LANES  = WWR_LANES_DEF,
  parameter int unsigned WORD_W = WWR_WORD_W_DEF,
  parameter int unsigned ADDR_W = WWR_ADDR_W_DEF,
  localparam int unsigned OFS_W   = $clog2(LANES),
  localparam int unsigned CHUNK_W = ADDR_W - OFS_W,
  localparam int unsigned ROW_W   = LANES * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_valid_i,
  input  logic [ADDR_W-1:0]  win_addr_i,
  output logic [CHUNK_W-1:0] rd_lo_addr_o,
  output logic [CHUNK_W-1:0] rd_hi_addr_o,
  input  logic [ROW_W-1:0]   lo_data_i,
  input  logic [ROW_W-1:0]   hi_data_i,
  output logic               lanes_valid_o,
  output logic [ROW_W-1:0]   lanes_o
);
  logic [OFS_W-1:0] req_ofs;
  logic             s1_vld;
  logic [OFS_W-1:0] s1_ofs;
  logic [ROW_W-1:0] routed;

  wwr_addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_split (
    .win_addr (win_addr_i),
    .chunk_lo (rd_lo_addr_o),
    .chunk_hi (rd_hi_addr_o),
    .ofs      (req_ofs)
  );

  wwr_sel_pipe #(.OFS_W(OFS_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (win_valid_i),
    .in_ofs  (req_ofs),
    .out_vld (s1_vld),
    .out_ofs (s1_ofs)
  );

  wwr_funnel #(.LANES(LANES), .WORD_W(WORD_W), .OFS_W(OFS_W)) u_funnel (
    .lo_row  (lo_data_i),
    .hi_row  (hi_data_i),
    .sel     (s1_ofs),
    .out_row (routed)
  );

  wwr_out_stage #(.DATA_W(ROW_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (s1_vld),
    .in_data  (routed),
    .out_vld  (lanes_valid_o),
    .out_data (lanes_o)
  );

  a_r3_next_chunk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi_addr_o == CHUNK_W'(rd_lo_addr_o + CHUNK_W'(1)));

  a_r4_stage_one: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_i |=> s1_vld);

  a_r4_stage_two: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> lanes_valid_o);

  a_r4_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !lanes_valid_o);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> $stable(lanes_o));

  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_ofs == '0) |=> lanes_o == $past(lo_data_i));

  a_r7_last_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_ofs == '1) |=>
      (lanes_o[WORD_W-1:0] == $past(lo_data_i[ROW_W-1 -: WORD_W]) &&
       lanes_o[ROW_W-1 -: WORD_W] == $past(hi_data_i[ROW_W-WORD_W-1 -: WORD_W])));
endmodule

// File: tb/tb_win_word_router.sv
module tb_win_word_router;
  localparam int LANES = 16;
  localparam int W     = 21;
  localparam int AW    = 13;
  localparam int CW    = 9;
  localparam int RW    = LANES * W;

  typedef struct {
    logic [RW-1:0] exp;
    int            issue;
    string         tag;
  } item_t;

  logic          clk;
  logic          rst_n;
  logic          win_valid_i;
  logic [AW-1:0] win_addr_i;
  logic [CW-1:0] rd_lo_addr_o, rd_hi_addr_o;
  logic [RW-1:0] lo_data_i, hi_data_i;
  logic          lanes_valid_o;
  logic [RW-1:0] lanes_o;
  logic          corrupt_hi;

  int     n_cmp = 0;
  int     n_bad = 0;
  int     cyc   = 0;
  item_t  sb[$];
  logic [RW-1:0] last_lanes = '0;

  win_word_router #(.LANES(LANES), .WORD_W(W), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .win_valid_i(win_valid_i), .win_addr_i(win_addr_i),
    .rd_lo_addr_o(rd_lo_addr_o), .rd_hi_addr_o(rd_hi_addr_o),
    .lo_data_i(lo_data_i), .hi_data_i(hi_data_i),
    .lanes_valid_o(lanes_valid_o), .lanes_o(lanes_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] word_at(input int p);
    return W'(((p & 8191) * 37) + 11);
  endfunction

  function automatic logic [RW-1:0] chunk_row(input logic [CW-1:0] c);
    logic [RW-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*W +: W] = word_at(int'(c) * LANES + k);
    return r;
  endfunction

  function automatic logic [RW-1:0] expect_row(input logic [AW-1:0] a);
    logic [RW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*W +: W] = word_at(int'(a) + i);
    return r;
  endfunction

  // memory copies: one cycle read latency, second copy optionally corrupted
  always @(posedge clk) begin
    lo_data_i <= chunk_row(rd_lo_addr_o);
    hi_data_i <= chunk_row(rd_hi_addr_o) ^ (corrupt_hi ? {(RW/2){2'b10}} : '0);
  end

  task automatic check(input bit ok, input string tag, input logic [RW-1:0] act,
                       input logic [RW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input bit corrupt, input string tag);
    item_t it;
    win_valid_i = 1'b1;
    win_addr_i  = a;
    corrupt_hi  = corrupt;
    it.exp   = expect_row(a);
    it.issue = cyc;
    it.tag   = tag;
    sb.push_back(it);
    #1;
    check(rd_lo_addr_o == a[AW-1:4], "R2",
          RW'(rd_lo_addr_o), RW'(a[AW-1:4]));
    check(rd_hi_addr_o == CW'(a[AW-1:4] + 1), "R3",
          RW'(rd_hi_addr_o), RW'(CW'(a[AW-1:4] + 1)));
    @(negedge clk);
    win_valid_i = 1'b0;
    corrupt_hi  = 1'b0;
  endtask

  task automatic idle(input int n);
    win_valid_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (lanes_valid_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R4 unexpected result", lanes_o, '0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(cyc == it.issue + 2, "R4 latency", RW'(cyc), RW'(it.issue + 2));
          check(lanes_o == it.exp, it.tag, lanes_o, it.exp);
        end
        last_lanes = lanes_o;
      end else begin
        check(lanes_o == last_lanes, "R8 hold (R1 before first result)",
              lanes_o, last_lanes);
      end
    end
  end

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    win_valid_i = 1'b0;
    win_addr_i = '0;
    corrupt_hi = 1'b0;
    repeat (3) @(negedge clk);
    check(lanes_valid_o == 1'b0 && lanes_o == '0, "R1", lanes_o, '0);
    rst_n = 1'b1;
    idle(2);

    // R5: start at x=3 routes words 3..18
    send(13'd3, 1'b0, "R5 offset 3");
    idle(3);
    // R6: aligned window, second copy corrupted but ignored
    send(13'd32, 1'b1, "R6 aligned, hi corrupted");
    idle(2);
    send(13'd0, 1'b1, "R6 aligned chunk 0");
    idle(2);
    // R7: last offset splits one word / fifteen words
    send(13'd47, 1'b0, "R7 offset 15");
    idle(2);
    // R3 wrap: chunk 511 followed by chunk 0
    send(13'd8191, 1'b0, "R3 R7 wrap at last chunk");
    idle(2);
    send(13'd8185, 1'b0, "R3 R5 wrap offset 9");
    idle(2);
    // R5: every offset within one chunk
    for (int s = 0; s < 16; s++) begin
      send(AW'(16 * 40 + s), 1'b0, "R5 offset sweep");
      idle(1);
    end
    // R9: back-to-back requests with mixed offsets
    for (int j = 0; j < 24; j++) begin
      send(AW'((j * 1237 + 5) & 8191), 1'b0, "R9 back-to-back");
    end
    idle(4);
    // R8: bubbles between sparse requests
    send(13'd1000, 1'b0, "R8 before bubble");
    idle(5);
    send(13'd4095, 1'b0, "R8 after bubble");
    idle(5);

    n_cmp++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R4: actual %0d pending expected 0", sb.size());
    end
    finish_run();
  end
endmodule